// File: doc/BRIEF.md
# Multidrop Serial Port with Test Loops

This block is a full-duplex asynchronous serial port. A character is 5 to 9 data bits, sent least significant bit first, between a low start bit and a high stop bit. A parity bit may follow the data. Its value can be even, odd, always 0 or always 1, or it can be left out. A baud divider produces a tick, and each bit lasts sixteen of these ticks. The receiver samples every bit at its centre. It reports a parity mismatch, a bad stop bit and a character lost because the previous one was not read. The transmitter can hold the line low to send a break, and the receiver recognises an incoming break.

In multidrop mode the parity position carries an address marker. The marker is taken from a configuration bit on transmit and reported in the status on receive. Four channel modes route the pins: normal; echo, where received bits are sent straight back out; local loop, where the transmitter feeds the receiver internally; and remote loop, where RX is sent back out on TX and the local receiver is cut off.

Software uses a four-word register bus. Address 0 holds the configuration, address 1 the divider, address 2 the data (a write transmits, a read fetches the received character) and address 3 the status (a write clears the error flags).

Top module: `usart_md`

## Requirements
- R1: After reset, tx_pin is high and a read of address 3 returns 0.
- R2: A write to address 2 while the transmitter is idle sends a frame on tx_pin: one low start bit, then nbits = 5 + cfg[2:0] data bits (length code 0..4) LSB first, then an optional parity bit, then one high stop bit. Each bit lasts 16*DIV clocks, where DIV is the value at address 1.
- R3: Configuration field cfg[5:3] selects the parity: 0 even (data plus parity has an even count of ones), 1 odd, 2 always 0, 3 always 1, 4 none (no parity bit).
- R4: The receiver rebuilds each character. Status bit 0 (ready) is then set and address 2 returns the data. A read of address 2 clears ready.
- R5: When parity is enabled and multidrop is off, a received parity bit that does not match sets status bit 3.
- R6: A zero stop bit on a character whose data is not all zero sets status bit 4, and the character is still delivered.
- R7: A character that completes while ready is still set sets status bit 5, and address 2 then returns the newer character.
- R8: While cfg[10] is set in normal mode, tx_pin is held low.
- R9: A received frame with all-zero data and a zero stop bit sets status bit 6 without setting ready or bit 4. The receiver stays idle until the line returns high, and then receives normally again.
- R10: With cfg[8] (multidrop) set, the parity position carries cfg[9] on transmit. On receive its value appears in status bit 2, and no parity error is raised.
- R11: In local loop (cfg[7:6]=2), tx_pin stays high and each transmitted character is received internally.
- R12: In echo (cfg[7:6]=1), tx_pin follows rx_pin one clock later, and the receiver still delivers the characters.
- R13: In remote loop (cfg[7:6]=3), tx_pin follows rx_pin and the receiver delivers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered one clock after bus_rd |
| rx_pin | input | 1 | Serial input |
| tx_pin | output | 1 | Serial output, registered |
| rx_ready | output | 1 | A received character is waiting |
| tx_busy | output | 1 | The transmitter is sending a frame |
| irq | output | 1 | Ready or any error or break flag |

## Verification
The hardest condition to reach is a break that must not be counted as a framing error. A bad stop bit and a break differ only in whether the data bits were zero. The bench therefore drives a frame that is low from the start bit through the stop bit and keeps the line low a little longer. It then checks that only the break flag is set, and sends a normal character to show that the receiver recovered. Overrun needs two complete characters with no read between them, so the bench drives them back to back on rx_pin. Multidrop marking is checked from both sides: on the pin in normal mode, and through the local loop.

// File: rtl/usart_md_pkg.sv
package usart_md_pkg;
  localparam int MAX_BITS = 9;
  localparam int FRAME_W  = MAX_BITS + 2;

  typedef enum logic [2:0] {
    PAR_EVEN = 3'd0, PAR_ODD = 3'd1, PAR_ZERO = 3'd2, PAR_ONE = 3'd3, PAR_NONE = 3'd4
  } par_e;

  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0, CH_ECHO = 2'd1, CH_LOCAL = 2'd2, CH_REMOTE = 2'd3
  } chan_e;

  typedef struct packed {
    logic       brk_tx;
    logic       tx_mark;
    logic       md;
    chan_e      chan;
    par_e       par;
    logic [2:0] len;
  } cfg_t;

  function automatic logic [3:0] char_bits(input logic [2:0] code);
    return (code > 3'd4) ? 4'd9 : 4'd5 + {1'b0, code};
  endfunction

  function automatic logic par_value(input logic [MAX_BITS-1:0] d,
                                     input logic [3:0] n, input par_e p);
    logic x;
    x = 1'b0;
    for (int i = 0; i < MAX_BITS; i++)
      if (i < int'(n)) x ^= d[i];
    case (p)
      PAR_EVEN: return x;
      PAR_ODD:  return ~x;
      PAR_ONE:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/usart_md_baud.sv
module usart_md_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || div == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && div > 1 && $stable(div)) |=> !tick);
endmodule

// File: rtl/usart_md_tx.sv
module usart_md_tx
  import usart_md_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                load,
  input  logic [MAX_BITS-1:0] data,
  input  logic [3:0]          nbits,
  input  logic                par_en,
  input  logic                par_bit,
  output logic                txd,
  output logic                busy
);
  localparam int OS_W = $clog2(OSR);

  logic [FRAME_W-1:0] frame, sh;
  logic [3:0]         left;
  logic [OS_W-1:0]    os;

  always_comb begin
    frame = '1;
    for (int i = 0; i < MAX_BITS; i++)
      if (i < int'(nbits)) frame[i] = data[i];
    if (par_en) frame[nbits] = par_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      sh   <= '1;
      left <= '0;
      os   <= '0;
    end else if (!busy) begin
      if (load) begin
        busy <= 1'b1;
        txd  <= 1'b0;
        sh   <= frame;
        left <= nbits + {3'd0, par_en} + 4'd1;
        os   <= '0;
      end
    end else if (tick) begin
      if (os == OS_W'(OSR - 1)) begin
        os <= '0;
        if (left == '0) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd  <= sh[0];
          sh   <= {1'b1, sh[FRAME_W-1:1]};
          left <= left - 1'b1;
        end
      end else begin
        os <= os + 1'b1;
      end
    end
  end

  p_idle_line_high_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |-> !txd);
endmodule

// File: rtl/usart_md_rx.sv
module usart_md_rx
  import usart_md_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                line,
  input  logic [3:0]          nbits,
  input  logic                par_en,
  output logic                done,
  output logic                brk,
  output logic [MAX_BITS-1:0] data,
  output logic                pbit,
  output logic                stop_ok
);
  localparam int OS_W = $clog2(OSR);
  localparam int HALF = OSR / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BITS, S_EVAL, S_WAITHI} st_e;
  st_e                st;
  logic [FRAME_W-1:0] sh;
  logic [3:0]         idx, total;
  logic [OS_W-1:0]    os;
  logic [MAX_BITS-1:0] masked;

  assign total = nbits + {3'd0, par_en} + 4'd1;

  always_comb begin
    masked = '0;
    for (int i = 0; i < MAX_BITS; i++)
      if (i < int'(nbits)) masked[i] = sh[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; os <= '0; idx <= '0; sh <= '0;
      done <= 1'b0; brk <= 1'b0; data <= '0; pbit <= 1'b0; stop_ok <= 1'b1;
    end else begin
      done <= 1'b0;
      brk  <= 1'b0;
      case (st)
        S_IDLE: if (tick && !line) begin st <= S_START; os <= '0; end
        S_START: if (tick) begin
          if (os == OS_W'(HALF - 1)) begin
            os  <= '0;
            idx <= '0;
            st  <= line ? S_IDLE : S_BITS;
          end else os <= os + 1'b1;
        end
        S_BITS: if (tick) begin
          if (os == OS_W'(OSR - 1)) begin
            os      <= '0;
            sh[idx] <= line;
            if (idx == total - 1'b1) st <= S_EVAL;
            else idx <= idx + 1'b1;
          end else os <= os + 1'b1;
        end
        S_EVAL: begin
          data    <= masked;
          pbit    <= sh[nbits];
          stop_ok <= sh[total-1'b1];
          if (masked == '0 && !sh[total-1'b1]) begin
            brk <= 1'b1;
            st  <= S_WAITHI;
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: if (line) st <= S_IDLE;
      endcase
    end
  end

  p_break_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAITHI) |-> !done);
  p_one_event_r9: assert property (@(posedge clk) disable iff (rst)
    !(done && brk));
endmodule

// File: rtl/usart_md.sv
module usart_md
  import usart_md_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int DIV_W = 16,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             rx_pin,
  output logic             tx_pin,
  output logic             rx_ready,
  output logic             tx_busy,
  output logic             irq
);
  localparam int CFG_W = $bits(cfg_t);

  cfg_t                cfg;
  logic [DIV_W-1:0]    div;
  logic                tick, txd, tx_line, rx_src, rx_s1, rx_s2;
  logic                par_en, rx_done, rx_brk, rx_pbit, rx_stop;
  logic [MAX_BITS-1:0] rx_word, rx_data;
  logic [3:0]          nbits;
  logic                rx_mark, par_err, frm_err, ovr_err, brk_flag;
  logic                tx_load, rd_data, clr_err;

  assign nbits   = char_bits(cfg.len);
  assign par_en  = cfg.md || (cfg.par < PAR_NONE);
  assign tx_load = bus_wr && bus_addr == 2'd2;
  assign rd_data = bus_rd && bus_addr == 2'd2;
  assign clr_err = bus_wr && bus_addr == 2'd3;
  assign tx_line = cfg.brk_tx ? 1'b0 : txd;

  always_comb begin
    case (cfg.chan)
      CH_LOCAL:  rx_src = tx_line;
      CH_REMOTE: rx_src = 1'b1;
      default:   rx_src = rx_pin;
    endcase
  end

  usart_md_baud #(.DIV_W(DIV_W)) u_baud (.clk(clk), .rst(rst), .div(div), .tick(tick));

  usart_md_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .load(tx_load),
    .data(bus_wdata[MAX_BITS-1:0]), .nbits(nbits), .par_en(par_en),
    .par_bit(cfg.md ? cfg.tx_mark : par_value(bus_wdata[MAX_BITS-1:0], nbits, cfg.par)),
    .txd(txd), .busy(tx_busy));

  usart_md_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .line(rx_s2), .nbits(nbits), .par_en(par_en),
    .done(rx_done), .brk(rx_brk), .data(rx_word), .pbit(rx_pbit), .stop_ok(rx_stop));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0; div <= '0; rx_s1 <= 1'b1; rx_s2 <= 1'b1; tx_pin <= 1'b1;
      rx_ready <= 1'b0; rx_data <= '0; rx_mark <= 1'b0;
      par_err <= 1'b0; frm_err <= 1'b0; ovr_err <= 1'b0; brk_flag <= 1'b0;
      bus_rdata <= '0; irq <= 1'b0;
    end else begin
      rx_s1 <= rx_src;
      rx_s2 <= rx_s1;
      case (cfg.chan)
        CH_ECHO, CH_REMOTE: tx_pin <= rx_pin;
        CH_LOCAL:           tx_pin <= 1'b1;
        default:            tx_pin <= tx_line;
      endcase
      if (bus_wr && bus_addr == 2'd0) cfg <= cfg_t'(bus_wdata[CFG_W-1:0]);
      if (bus_wr && bus_addr == 2'd1) div <= bus_wdata[DIV_W-1:0];
      if (rd_data) rx_ready <= 1'b0;
      if (clr_err) begin
        par_err <= 1'b0; frm_err <= 1'b0; ovr_err <= 1'b0; brk_flag <= 1'b0;
      end
      if (rx_brk) brk_flag <= 1'b1;
      if (rx_done) begin
        rx_ready <= 1'b1;
        rx_data  <= rx_word;
        rx_mark  <= cfg.md && rx_pbit;
        if (rx_ready && !rd_data) ovr_err <= 1'b1;
        if (!rx_stop) frm_err <= 1'b1;
        if (!cfg.md && cfg.par < PAR_NONE && rx_pbit != par_value(rx_word, nbits, cfg.par))
          par_err <= 1'b1;
      end
      irq <= rx_ready | par_err | frm_err | ovr_err | brk_flag;
      if (bus_rd) begin
        case (bus_addr)
          2'd0:    bus_rdata <= BUS_W'(cfg);
          2'd1:    bus_rdata <= BUS_W'(div);
          2'd2:    bus_rdata <= BUS_W'(rx_data);
          default: bus_rdata <= BUS_W'({brk_flag, ovr_err, frm_err, par_err,
                                        rx_mark, tx_busy, rx_ready});
        endcase
      end
    end
  end

  p_local_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg.chan == CH_LOCAL) |=> tx_pin);
  p_break_low_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg.chan == CH_NORMAL && cfg.brk_tx) |=> !tx_pin);
  p_ovr_with_ready_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_err) |-> rx_ready);
  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !rx_done) |=> !rx_ready);
  p_remote_deaf_r13: assert property (@(posedge clk) disable iff (rst)
    (cfg.chan == CH_REMOTE && $past(cfg.chan) == CH_REMOTE && rx_s2) |=> rx_s2);
endmodule

// File: tb/usart_md_test.sv
module usart_md_test;
  localparam int DIV = 4;
  localparam int BT  = 16 * DIV;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        rx_pin = 1'b1, tx_pin, rx_ready, tx_busy, irq;

  int checks = 0, fails = 0;
  bit mon_on = 1'b0;
  logic [10:0] exp_q[$];
  int          len_q[$];
  string       tag_q[$];

  usart_md uut (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_pin(rx_pin), .tx_pin(tx_pin),
    .rx_ready(rx_ready), .tx_busy(tx_busy), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  // frame payload after the start bit, LSB first: data, optional parity/marker, stop
  task automatic mk(input logic [8:0] d, input int nb, input int pm, input bit md,
                    input bit mark, input bit stopb, output logic [10:0] f, output int n);
    bit p;
    p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    f = '1;
    for (int i = 0; i < nb; i++) f[i] = d[i];
    n = nb;
    if (md) begin f[n] = mark; n++; end
    else if (pm < 4) begin
      f[n] = (pm == 0) ? p : (pm == 1) ? ~p : (pm == 3);
      n++;
    end
    f[n] = stopb; n++;
  endtask

  task automatic send_tx(input logic [8:0] d, input int nb, input int pm, input bit md,
                         input bit mark, input string tag);
    logic [10:0] f; int n;
    mk(d, nb, pm, md, mark, 1'b1, f, n);
    exp_q.push_back(f); len_q.push_back(n); tag_q.push_back(tag);
    bus_write(2'd2, {7'd0, d});
    wait_clk((n + 3) * BT);
  endtask

  task automatic drive(input logic [10:0] f, input int n, input bit follow, input string tag);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk); rx_pin = (i == 0) ? 1'b0 : f[i-1];
      wait_clk(BT / 2); #1;
      if (follow) chk(tx_pin == rx_pin, tag, tx_pin, rx_pin);
      wait_clk(BT - BT / 2 - 1);
    end
    @(negedge clk); rx_pin = 1'b1;
    wait_clk(2 * BT);
  endtask

  // monitor: decodes tx_pin and compares against the scoreboard queue
  initial begin
    forever begin
      @(negedge tx_pin);
      if (mon_on) begin
        logic [10:0] f, got; int n; string tag;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", 0, 0);
        end else begin
          f = exp_q.pop_front(); n = len_q.pop_front(); tag = tag_q.pop_front();
          got = '1;
          wait_clk(BT / 2); #1;
          chk(tx_pin == 1'b0, {tag, " start"}, tx_pin, 0);
          for (int i = 0; i < n; i++) begin
            wait_clk(BT); #1;
            got[i] = tx_pin;
          end
          chk(got == f, tag, got, f);
        end
      end
    end
  end

  initial begin
    wait_clk(200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] v; logic [10:0] f; int n;
    wait_clk(4); @(negedge clk); rst = 1'b0;
    #1;
    chk(tx_pin == 1'b1, "R1 tx idle", tx_pin, 1);
    bus_read(2'd3, v);
    chk(v == 0, "R1 status", v, 0);
    bus_write(2'd1, DIV);

    // transmit formats on the pin
    mon_on = 1'b1;
    bus_write(2'd0, 16'h023); send_tx(9'h0A5, 8, 4, 0, 0, "R2 8N");
    bus_write(2'd0, 16'h002); send_tx(9'h035, 7, 0, 0, 0, "R3 7E");
    bus_write(2'd0, 16'h008); send_tx(9'h013, 5, 1, 0, 0, "R3 5O");
    bus_write(2'd0, 16'h01C); send_tx(9'h1A5, 9, 3, 0, 0, "R3 9 one");
    bus_write(2'd0, 16'h011); send_tx(9'h02A, 6, 2, 0, 0, "R3 6 zero");
    bus_write(2'd0, 16'h303); send_tx(9'h042, 8, 0, 1, 1, "R10 mark1");
    bus_write(2'd0, 16'h103); send_tx(9'h042, 8, 0, 1, 0, "R10 mark0");
    chk(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
    mon_on = 1'b0;

    // break transmit
    bus_write(2'd0, 16'h423); wait_clk(3); #1;
    chk(tx_pin == 1'b0, "R8 break low", tx_pin, 0);
    bus_write(2'd0, 16'h023); wait_clk(3); #1;
    chk(tx_pin == 1'b1, "R8 break released", tx_pin, 1);

    // local loop
    bus_write(2'd0, 16'h083);
    bus_write(2'd2, 16'h05C);
    wait_clk(5 * BT); #1;
    chk(tx_pin == 1'b1, "R11 pin quiet", tx_pin, 1);
    wait_clk(8 * BT);
    bus_read(2'd3, v);
    chk(v[0] == 1'b1 && v[3] == 1'b0, "R11 loop ready", v, 1);
    bus_read(2'd2, v);
    chk(v == 16'h05C, "R11 loop data", v, 16'h05C);
    bus_read(2'd3, v);
    chk(v[0] == 1'b0, "R4 read clears ready", v[0], 0);

    // multidrop through the loop
    bus_write(2'd0, 16'h383);
    bus_write(2'd2, 16'h042);
    wait_clk(14 * BT);
    bus_read(2'd3, v);
    chk(v[2] == 1'b1 && v[3] == 1'b0, "R10 marker received", v, 16'h5);
    bus_read(2'd2, v);
    chk(v == 16'h042, "R10 data", v, 16'h042);

    // parity error on receive
    bus_write(2'd0, 16'h003); bus_write(2'd3, 0);
    mk(9'h00F, 8, 0, 0, 0, 1'b1, f, n); f[8] = ~f[8];
    drive(f, n, 1'b0, "");
    bus_read(2'd3, v);
    chk(v[3] == 1'b1 && v[0] == 1'b1, "R5 parity error", v, 16'h9);
    bus_read(2'd2, v);
    chk(v == 16'h00F, "R4 received data", v, 16'h00F);

    // framing error
    bus_write(2'd0, 16'h023); bus_write(2'd3, 0);
    mk(9'h055, 8, 4, 0, 0, 1'b0, f, n);
    drive(f, n, 1'b0, "");
    bus_read(2'd3, v);
    chk(v[4] == 1'b1 && v[0] == 1'b1 && v[6] == 1'b0, "R6 framing", v, 16'h11);
    bus_read(2'd2, v);

    // overrun
    bus_write(2'd3, 0);
    mk(9'h011, 8, 4, 0, 0, 1'b1, f, n); drive(f, n, 1'b0, "");
    mk(9'h022, 8, 4, 0, 0, 1'b1, f, n); drive(f, n, 1'b0, "");
    bus_read(2'd3, v);
    chk(v[5] == 1'b1, "R7 overrun flag", v, 16'h21);
    bus_read(2'd2, v);
    chk(v == 16'h022, "R7 newer kept", v, 16'h022);

    // break receive, then recovery
    bus_write(2'd3, 0);
    f = '0;
    @(negedge clk); rx_pin = 1'b0;
    wait_clk(12 * BT);
    @(negedge clk); rx_pin = 1'b1;
    wait_clk(2 * BT);
    bus_read(2'd3, v);
    chk(v[6] == 1'b1 && v[0] == 1'b0 && v[4] == 1'b0, "R9 break only", v, 16'h40);
    mk(9'h03C, 8, 4, 0, 0, 1'b1, f, n); drive(f, n, 1'b0, "");
    bus_read(2'd2, v);
    chk(v == 16'h03C, "R9 recovery", v, 16'h03C);

    // echo
    bus_write(2'd0, 16'h063);
    mk(9'h096, 8, 4, 0, 0, 1'b1, f, n); drive(f, n, 1'b1, "R12 echo follows");
    bus_read(2'd3, v);
    chk(v[0] == 1'b1, "R12 echo ready", v[0], 1);
    bus_read(2'd2, v);
    chk(v == 16'h096, "R12 echo data", v, 16'h096);

    // remote loop
    bus_write(2'd0, 16'h0E3);
    mk(9'h069, 8, 4, 0, 0, 1'b1, f, n); drive(f, n, 1'b1, "R13 remote follows");
    bus_read(2'd3, v);
    chk(v[0] == 1'b0, "R13 receiver off", v[0], 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule